// File: doc/BRIEF.md
# Load-Use Interlock Unit

This block decides when a five-stage in-order pipeline (Fetch, Decode, Execute, Memory, Write) must hold the instruction in Decode because a recently issued load has not yet produced its value. Each cycle it is given a descriptor of the Decode instruction. The descriptor lists which read ports the instruction uses (A, B, C), its source registers, whether it is a block transfer or a store-multiple, the first register a store-multiple stores, and what the instruction itself writes. When the instruction issues, the block records that descriptor internally. It keeps a short age-stamped history of issued loads, and it raises a Decode-stage stall or a separate Execute-stage stall for as many unwaited clock cycles as the hazard needs.

The length of an interlock depends on two things: the size of the load, and the read port that consumes the value. Sub-word loads need one more cycle than word loads on the A and B ports. Loaded data is never forwarded to the C port, which carries store data and the accumulate operand. A store-multiple whose first stored register comes from the directly preceding load is held in Execute for one cycle, and that hold is reported apart from the Decode stall. A memory wait input freezes the whole unit, so wait cycles never shorten an interlock.

Top module: `lsi_interlock`

## Requirements
- R1: After reset both stall outputs are low and no load is pending, so the first instruction issues without stalling.
- R2: A word load (size code 2'b10) followed directly by an instruction that reads its destination on port A or B raises the Decode stall for exactly one unwaited cycle.
- R3: A byte load (size code 2'b00) or a halfword load (size code 2'b01) followed directly by an A/B-port consumer raises the Decode stall for exactly two unwaited cycles; no Decode stall ever lasts longer than that.
- R4: Each instruction that issues between a load and its consumer shortens the remaining stall by one cycle. A second dependent instruction that follows a stalled consumer does not stall.
- R5: If an instruction flagged multi-cycle issues between a load and its consumer, the consumer does not stall.
- R6: A C-port read (dec_use_c) of a load's destination stalls one cycle when it directly follows a load of any size, and does not stall when one instruction lies between them.
- R7: For a block transfer (dec_blk), only the base register on port A is checked in Decode. Its B and C port requests are ignored.
- R8: A store-multiple (dec_stm) whose first stored register is the destination of the directly preceding load raises ex_stall for exactly one cycle in the cycle after it issues, with no Decode stall. With one instruction between the load and the store-multiple, there is no stall.
- R9: While hold is high, all state is frozen and ex_stall is held stable. Stall lengths count only cycles with hold low.
- R10: Sources equal to register 15, and sources that match no pending load destination, never cause a stall. A load whose destination is register 15 never interlocks.
- R11: An instruction that writes a register (dec_wr) and issues after a load to the same register cancels that load's interlock for later readers.
- R12: dec_stall is low whenever dec_valid is low. A held instruction re-evaluates its hazards every cycle, so time spent with dec_valid low counts toward clearing the hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Memory wait: freezes the pipeline and this unit |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_use_a | input | 1 | Port A is read |
| dec_rs_a | input | RW | Port A source register (block-transfer base) |
| dec_use_b | input | 1 | Port B is read |
| dec_rs_b | input | RW | Port B source register |
| dec_use_c | input | 1 | Port C is read (store data or accumulate operand) |
| dec_rs_c | input | RW | Port C source register |
| dec_blk | input | 1 | Load-multiple or store-multiple |
| dec_stm | input | 1 | Store-multiple |
| dec_first | input | RW | First register stored by a store-multiple |
| dec_wr | input | 1 | Instruction writes a register |
| dec_rd | input | RW | Destination register |
| dec_load | input | 1 | Instruction is a load |
| dec_size | input | 2 | Load size: 00 byte, 01 halfword, 10 word |
| dec_multi | input | 1 | Instruction occupies Execute for several cycles |
| dec_stall | output | 1 | Hold the instruction in Decode |
| ex_stall | output | 1 | Second-cycle hold of a store-multiple in Execute |
| dec_issue | output | 1 | Decode instruction advances at the next edge |

## Verification
Five properties are checked on every cycle: no Decode stall appears without a valid instruction, no Decode stall run exceeds the sub-word load latency, the Execute stall never exceeds its one-cycle bound, hold freezes ex_stall, and an A-only read of register 15 never stalls. The exact stall counts can only be shown by the directed scenarios, which replay instruction sequences and compare each count against values derived from the requirements. These counts include word against sub-word loads, the C port with and without a spacer, suppression by a multi-cycle instruction, cancellation by an overwriting instruction, the store-multiple Execute hold and stretching by wait cycles.

// File: rtl/lsi_interlock.sv
module lsi_interlock #(
  parameter int RW       = 4,
  parameter int WORD_LAT = 1,
  parameter int SUB_LAT  = 2,
  parameter int C_LAT    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          dec_valid,
  input  logic          dec_use_a,
  input  logic [RW-1:0] dec_rs_a,
  input  logic          dec_use_b,
  input  logic [RW-1:0] dec_rs_b,
  input  logic          dec_use_c,
  input  logic [RW-1:0] dec_rs_c,
  input  logic          dec_blk,
  input  logic          dec_stm,
  input  logic [RW-1:0] dec_first,
  input  logic          dec_wr,
  input  logic [RW-1:0] dec_rd,
  input  logic          dec_load,
  input  logic [1:0]    dec_size,
  input  logic          dec_multi,
  output logic          dec_stall,
  output logic          ex_stall,
  output logic          dec_issue
);

  localparam int NREG    = 1 << RW;
  localparam int PC_REG  = NREG - 1;
  localparam int STM_LAT = C_LAT + 1;
  localparam int AB_MAX  = (SUB_LAT > WORD_LAT) ? SUB_LAT : WORD_LAT;
  localparam int MAXLAT  = (AB_MAX > STM_LAT) ? AB_MAX : STM_LAT;
  localparam int DEPTH   = MAXLAT;
  localparam int AW      = $clog2(MAXLAT + 1);
  localparam logic [AW-1:0] AGE_SAT = AW'(MAXLAT);
  localparam logic [1:0]    SZ_WORD = 2'b10;
  localparam logic [RW-1:0] PC_ID   = RW'(PC_REG);

  logic [DEPTH-1:0] e_ld, e_sub;
  logic [RW-1:0]    e_rd  [DEPTH];
  logic [AW-1:0]    e_age [DEPTH];

  logic [DEPTH-1:0] young_ab, young_c, hit_a, hit_b, hit_c, kill;

  logic          ex_stm, sh_hit;
  logic [AW-1:0] sh_age;
  logic          f_hit;
  logic [AW-1:0] f_age;

  function automatic logic [AW-1:0] inc_age(input logic [AW-1:0] a);
    return (a == AGE_SAT) ? a : a + 1'b1;
  endfunction

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign young_ab[k] = int'(e_age[k]) < (e_sub[k] ? SUB_LAT : WORD_LAT);
    assign young_c[k]  = int'(e_age[k]) < C_LAT;
    assign hit_a[k]    = e_ld[k] && young_ab[k] && (e_rd[k] == dec_rs_a);
    assign hit_b[k]    = e_ld[k] && young_ab[k] && (e_rd[k] == dec_rs_b);
    assign hit_c[k]    = e_ld[k] && young_c[k]  && (e_rd[k] == dec_rs_c);
    assign kill[k]     = dec_multi || (dec_wr && (e_rd[k] == dec_rd));
  end

  wire use_a = dec_use_a && (dec_rs_a != PC_ID);
  wire use_b = dec_use_b && !dec_blk && (dec_rs_b != PC_ID);
  wire use_c = dec_use_c && !dec_blk && (dec_rs_c != PC_ID);

  assign dec_stall = dec_valid && ((use_a && |hit_a) || (use_b && |hit_b) || (use_c && |hit_c));
  assign ex_stall  = ex_stm && sh_hit && (int'(sh_age) < STM_LAT);
  assign dec_issue = dec_valid && !dec_stall && !ex_stall && !hold;

  always_comb begin
    f_hit = 1'b0;
    f_age = AGE_SAT;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (e_ld[k] && (e_rd[k] == dec_first) && (dec_first != PC_ID)) begin
        f_hit = 1'b1;
        f_age = e_age[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_ld   <= '0;
      e_sub  <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        e_rd[k]  <= '0;
        e_age[k] <= AGE_SAT;
      end
      ex_stm <= 1'b0;
      sh_hit <= 1'b0;
      sh_age <= AGE_SAT;
    end else if (!hold) begin
      if (dec_issue) begin
        e_ld[0]  <= dec_load && (dec_rd != PC_ID);
        e_sub[0] <= (dec_size != SZ_WORD);
        e_rd[0]  <= dec_rd;
        e_age[0] <= '0;
        for (int k = 1; k < DEPTH; k++) begin
          e_ld[k]  <= e_ld[k-1] && !kill[k-1];
          e_sub[k] <= e_sub[k-1];
          e_rd[k]  <= e_rd[k-1];
          e_age[k] <= inc_age(e_age[k-1]);
        end
      end else begin
        for (int k = 0; k < DEPTH; k++) e_age[k] <= inc_age(e_age[k]);
      end
      if (!ex_stall) begin
        ex_stm <= dec_issue && dec_stm;
        sh_hit <= f_hit;
        sh_age <= inc_age(f_age);
      end else begin
        sh_age <= inc_age(sh_age);
      end
    end
  end

endmodule

module lsi_interlock_chk #(
  parameter int RW      = 4,
  parameter int MAX_RUN = 2,
  parameter int STM_LAT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          dec_valid,
  input logic          dec_use_a,
  input logic [RW-1:0] dec_rs_a,
  input logic          dec_use_b,
  input logic          dec_use_c,
  input logic          dec_stall,
  input logic          ex_stall
);

  logic [7:0] run, ex_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      ex_run <= '0;
    end else if (!hold) begin
      run    <= dec_stall ? ((run == 8'hff) ? run : run + 8'd1) : 8'd0;
      ex_run <= ex_stall  ? ((ex_run == 8'hff) ? ex_run : ex_run + 8'd1) : 8'd0;
    end
  end

  // R12
  stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_stall);

  // R3
  stall_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> (int'(run) < MAX_RUN));

  // R8
  ex_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_stall |-> (int'(ex_run) < STM_LAT - 1));

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(ex_stall));

  // R10
  pc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_use_a && (dec_rs_a == {RW{1'b1}}) && !dec_use_b && !dec_use_c) |-> !dec_stall);

endmodule

bind lsi_interlock lsi_interlock_chk #(
  .RW(RW),
  .MAX_RUN((SUB_LAT > WORD_LAT) ? SUB_LAT : WORD_LAT),
  .STM_LAT(C_LAT + 1)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hold(hold), .dec_valid(dec_valid),
  .dec_use_a(dec_use_a), .dec_rs_a(dec_rs_a), .dec_use_b(dec_use_b),
  .dec_use_c(dec_use_c), .dec_stall(dec_stall), .ex_stall(ex_stall)
);

// File: tb/lsi_interlock_tb.sv
module lsi_interlock_tb_top;

  typedef struct packed {
    logic       ua; logic [3:0] a;
    logic       ub; logic [3:0] b;
    logic       uc; logic [3:0] c;
    logic       blk; logic stm; logic [3:0] first;
    logic       wr; logic [3:0] rd;
    logic       ld; logic [1:0] sz; logic multi;
  } ins_t;

  logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, dec_valid = 1'b0;
  logic dec_use_a = 1'b0, dec_use_b = 1'b0, dec_use_c = 1'b0;
  logic [3:0] dec_rs_a = '0, dec_rs_b = '0, dec_rs_c = '0, dec_first = '0, dec_rd = '0;
  logic dec_blk = 1'b0, dec_stm = 1'b0, dec_wr = 1'b0, dec_load = 1'b0, dec_multi = 1'b0;
  logic [1:0] dec_size = 2'b10;
  logic dec_stall, ex_stall, dec_issue;

  int n_run = 0, n_fail = 0, hold_left = 0;
  int st, ex, cyc;

  always #10 clk = ~clk;

  lsi_interlock dut_i (
    .clk(clk), .rst_n(rst_n), .hold(hold), .dec_valid(dec_valid),
    .dec_use_a(dec_use_a), .dec_rs_a(dec_rs_a), .dec_use_b(dec_use_b), .dec_rs_b(dec_rs_b),
    .dec_use_c(dec_use_c), .dec_rs_c(dec_rs_c), .dec_blk(dec_blk), .dec_stm(dec_stm),
    .dec_first(dec_first), .dec_wr(dec_wr), .dec_rd(dec_rd), .dec_load(dec_load),
    .dec_size(dec_size), .dec_multi(dec_multi), .dec_stall(dec_stall),
    .ex_stall(ex_stall), .dec_issue(dec_issue)
  );

  function automatic ins_t nop();
    ins_t d = '0;
    d.sz = 2'b10;
    return d;
  endfunction
  function automatic ins_t ld(input logic [3:0] rd, input logic [1:0] sz, input logic [3:0] base);
    ins_t d = nop();
    d.ua = 1; d.a = base; d.wr = 1; d.rd = rd; d.ld = 1; d.sz = sz;
    return d;
  endfunction
  function automatic ins_t alu(input logic [3:0] rd, input logic [3:0] a, input logic [3:0] b);
    ins_t d = nop();
    d.ua = 1; d.a = a; d.ub = 1; d.b = b; d.wr = 1; d.rd = rd;
    return d;
  endfunction
  function automatic ins_t str_i(input logic [3:0] data, input logic [3:0] base);
    ins_t d = nop();
    d.ua = 1; d.a = base; d.uc = 1; d.c = data;
    return d;
  endfunction
  function automatic ins_t stm_i(input logic [3:0] base, input logic [3:0] first);
    ins_t d = nop();
    d.ua = 1; d.a = base; d.blk = 1; d.stm = 1; d.first = first;
    return d;
  endfunction

  task automatic put(input ins_t d, input logic v);
    dec_valid = v;
    dec_use_a = d.ua; dec_rs_a = d.a; dec_use_b = d.ub; dec_rs_b = d.b;
    dec_use_c = d.uc; dec_rs_c = d.c; dec_blk = d.blk; dec_stm = d.stm;
    dec_first = d.first; dec_wr = d.wr; dec_rd = d.rd; dec_load = d.ld;
    dec_size = d.sz; dec_multi = d.multi;
  endtask

  task automatic issue(input ins_t d);
    logic done;
    put(d, 1'b1);
    st = 0; ex = 0; cyc = 0;
    forever begin
      if (hold_left > 0) begin hold = 1'b1; hold_left--; end else hold = 1'b0;
      #1;
      cyc++;
      if (!hold) begin
        if (dec_stall) st++;
        if (ex_stall) ex++;
      end
      done = dec_issue;
      @(negedge clk);
      if (done || cyc > 100) break;
    end
    hold = 1'b0;
    put(nop(), 1'b0);
  endtask

  task automatic idle(input int n);
    put(nop(), 1'b0);
    hold = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(dec_stall == 1'b0, "R1", "dec_stall after reset", int'(dec_stall), 0);
    chk(ex_stall == 1'b0, "R1", "ex_stall after reset", int'(ex_stall), 0);
    issue(alu(4'd2, 4'd0, 4'd1));
    chk(st == 0, "R1", "first consumer stalls", st, 0);
  endtask

  task automatic t_word();
    idle(3);
    issue(ld(4'd0, 2'b10, 4'd1));
    issue(alu(4'd2, 4'd0, 4'd3));
    chk(st == 1, "R2", "word load A-port stall", st, 1);
    idle(3);
    issue(ld(4'd4, 2'b10, 4'd1));
    issue(alu(4'd2, 4'd3, 4'd4));
    chk(st == 1, "R2", "word load B-port stall", st, 1);
  endtask

  task automatic t_sub();
    idle(3);
    issue(ld(4'd0, 2'b00, 4'd1));
    issue(alu(4'd2, 4'd0, 4'd3));
    chk(st == 2, "R3", "byte load stall", st, 2);
    issue(alu(4'd4, 4'd0, 4'd5));
    chk(st == 0, "R4", "second consumer after stalled one", st, 0);
    idle(3);
    issue(ld(4'd6, 2'b01, 4'd1));
    issue(alu(4'd2, 4'd3, 4'd6));
    chk(st == 2, "R3", "halfword load stall", st, 2);
  endtask

  task automatic t_spacer();
    idle(3);
    issue(ld(4'd0, 2'b00, 4'd1));
    issue(alu(4'd8, 4'd9, 4'd10));
    issue(alu(4'd2, 4'd0, 4'd3));
    chk(st == 1, "R4", "byte load with one spacer", st, 1);
    idle(3);
    issue(ld(4'd0, 2'b10, 4'd1));
    issue(alu(4'd8, 4'd9, 4'd10));
    issue(alu(4'd2, 4'd0, 4'd3));
    chk(st == 0, "R4", "word load with one spacer", st, 0);
  endtask

  task automatic t_multi();
    ins_t m;
    idle(3);
    m = alu(4'd8, 4'd6, 4'd7);
    m.multi = 1'b1;
    issue(ld(4'd0, 2'b00, 4'd1));
    issue(m);
    chk(st == 0, "R5", "independent multi-cycle", st, 0);
    issue(alu(4'd4, 4'd0, 4'd5));
    chk(st == 0, "R5", "consumer after multi-cycle", st, 0);
  endtask

  task automatic t_cport();
    ins_t m;
    idle(3);
    issue(ld(4'd0, 2'b10, 4'd1));
    issue(str_i(4'd0, 4'd2));
    chk(st == 1, "R6", "store data after word load", st, 1);
    idle(3);
    issue(ld(4'd0, 2'b00, 4'd1));
    issue(str_i(4'd0, 4'd2));
    chk(st == 1, "R6", "store data after byte load", st, 1);
    idle(3);
    issue(ld(4'd0, 2'b10, 4'd1));
    issue(nop());
    issue(str_i(4'd0, 4'd2));
    chk(st == 0, "R6", "store data with spacer", st, 0);
    idle(3);
    m = alu(4'd4, 4'd5, 4'd6);
    m.uc = 1'b1; m.c = 4'd0; m.multi = 1'b1;
    issue(ld(4'd0, 2'b10, 4'd1));
    issue(m);
    chk(st == 1, "R6", "accumulate operand after load", st, 1);
  endtask

  task automatic t_blk();
    ins_t b;
    idle(3);
    issue(ld(4'd0, 2'b10, 4'd1));
    issue(stm_i(4'd0, 4'd1));
    chk(st == 1, "R7", "block base after load", st, 1);
    idle(3);
    b = nop();
    b.ua = 1; b.a = 4'd5; b.blk = 1; b.ub = 1; b.b = 4'd0; b.uc = 1; b.c = 4'd0;
    issue(ld(4'd0, 2'b00, 4'd1));
    issue(b);
    chk(st == 0, "R7", "block B/C requests ignored", st, 0);
  endtask

  task automatic t_stm();
    idle(3);
    issue(ld(4'd0, 2'b10, 4'd1));
    issue(stm_i(4'd3, 4'd0));
    chk(st == 0, "R8", "store-multiple decode stall", st, 0);
    issue(nop());
    chk(ex == 1, "R8", "second-cycle ex_stall", ex, 1);
    chk(st == 0, "R8", "no decode stall during ex hold", st, 0);
    idle(3);
    issue(ld(4'd0, 2'b10, 4'd1));
    issue(nop());
    issue(stm_i(4'd3, 4'd0));
    issue(nop());
    chk(ex == 0, "R8", "ex_stall with spacer", ex, 0);
  endtask

  task automatic t_hold();
    idle(3);
    issue(ld(4'd0, 2'b00, 4'd1));
    hold_left = 2;
    issue(alu(4'd2, 4'd0, 4'd3));
    chk(st == 2, "R9", "unwaited stall cycles", st, 2);
    chk(cyc == 5, "R9", "cycles in decode incl waits", cyc, 5);
  endtask

  task automatic t_pc();
    idle(3);
    issue(ld(4'd15, 2'b00, 4'd1));
    issue(alu(4'd2, 4'd15, 4'd15));
    chk(st == 0, "R10", "register 15 source", st, 0);
    idle(3);
    issue(ld(4'd0, 2'b00, 4'd1));
    issue(alu(4'd2, 4'd5, 4'd6));
    chk(st == 0, "R10", "unrelated sources", st, 0);
  endtask

  task automatic t_kill();
    idle(3);
    issue(ld(4'd0, 2'b00, 4'd1));
    issue(alu(4'd0, 4'd9, 4'd10));
    issue(alu(4'd2, 4'd0, 4'd3));
    chk(st == 0, "R11", "overwritten load destination", st, 0);
  endtask

  task automatic t_valid();
    idle(3);
    issue(ld(4'd0, 2'b00, 4'd1));
    put(alu(4'd2, 4'd0, 4'd3), 1'b0);
    #1;
    chk(dec_stall == 1'b0, "R12", "stall without valid", int'(dec_stall), 0);
    @(negedge clk);
    issue(alu(4'd2, 4'd0, 4'd3));
    chk(st == 1, "R12", "re-evaluated remaining stall", st, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word();
    t_sub();
    t_spacer();
    t_multi();
    t_cport();
    t_blk();
    t_stm();
    t_hold();
    t_pc();
    t_kill();
    t_valid();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 20000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule